// File: doc/BRIEF.md
# Transmit descriptor ring engine

The engine walks a ring of transmit descriptors kept in a small local memory. Software fills the descriptors through a word-addressed register port, hands each one over by setting its ownership flag, and writes a poll demand to start or wake the walker. For every descriptor it owns, the engine sends one buffer-read request to a buffer source and keeps that request up until the source reports the buffer fully read. It then closes the descriptor by clearing only the ownership flag and moves to the next slot. At an end-of-ring marker it goes back to slot 0.

A frame can span several descriptors. Its first descriptor carries the per-frame controls: CRC suppression, pad suppression, time-stamp enable and a two-bit checksum-insertion code. The engine latches these controls and presents them unchanged with every segment of the frame. The same bits on later segments have no effect. A descriptor that does not start a frame and is met outside any frame is an orphan: it is closed without a data request, and a sticky error is raised. An interrupt request on any descriptor of a frame sets a sticky transmit interrupt once the frame's last descriptor closes. When the walker meets a descriptor that software still owns, it parks and shows buffer-unavailable until the next poll demand.

Address map: `cpu_addr[0]` selects the word (0 = control word, 1 = length word) and the upper bits give the slot. Control-word bits: 31 ownership (1 = engine), 30 interrupt request, 29 last segment, 28 first segment, 27 CRC off, 26 pad off, 25 time-stamp on, 23:22 checksum code, 21 end of ring. The length word's bits 15:0 hold the buffer length.

Top module: `txdr_engine`

## Requirements
- R1: The engine requests a buffer only for a descriptor whose control-word bit 31 is 1. A slot with bit 31 at 0 never produces `buf_req`.
- R2: On reaching a slot with bit 31 at 0, the engine raises `buf_unavail`, makes no request, and stays parked until a `cpu_poll` pulse. After reset a `cpu_poll` pulse starts the walk at slot 0.
- R3: Closing a descriptor clears control-word bit 31 and leaves every other bit of both words as software wrote them.
- R4: `seg_first` and `seg_last` show bits 28 and 29 of the descriptor being served. A frame runs from a bit-28 descriptor to a bit-29 descriptor across any number of slots.
- R5: Bits 27, 26 and 25 of a frame's first descriptor appear on `f_crc_dis`, `f_pad_dis` and `f_ts_en` for every segment of that frame. The same bits on later segments are ignored.
- R6: The checksum code in bits 23:22 of the first descriptor (00 off, 01 header, 10 header+payload, 11 header+payload+pseudo-header) is passed unchanged on `f_csum` for the whole frame.
- R7: If any descriptor of a frame has bit 30 set, `tx_irq` rises after the frame's last descriptor closes, and not before. It stays high until an `irq_ack` pulse.
- R8: After closing a descriptor with bit 21 set, the next slot examined is 0. Otherwise the next slot is the current one plus 1, modulo the ring size.
- R9: An owned descriptor without bit 28, met outside a frame, is closed with no `buf_req` and sets `orphan_err`, which stays set until `irq_ack`.
- R10: `buf_req` stays high with a stable `buf_idx` and `buf_len` (length word bits 15:0) until `buf_done`.
- R11: After reset all outputs are 0, and `buf_unavail` is 0 until the walker first parks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Descriptor word write strobe |
| cpu_addr | input | IW+1 | {slot, word select} |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data of the addressed word |
| cpu_poll | input | 1 | Poll demand pulse |
| irq_ack | input | 1 | Clears tx_irq and orphan_err |
| buf_req | output | 1 | Buffer read request |
| buf_idx | output | IW | Slot being served |
| buf_len | output | 16 | Buffer length of that slot |
| seg_first | output | 1 | Served slot starts a frame |
| seg_last | output | 1 | Served slot ends a frame |
| f_crc_dis | output | 1 | Frame CRC suppression |
| f_pad_dis | output | 1 | Frame pad suppression |
| f_ts_en | output | 1 | Frame time-stamp enable |
| f_csum | output | 2 | Frame checksum-insertion code |
| buf_done | input | 1 | Buffer fully read |
| tx_irq | output | 1 | Sticky transmit interrupt |
| orphan_err | output | 1 | Sticky orphan-segment error |
| buf_unavail | output | 1 | Walker parked on a software-owned slot |

## Verification
Two situations are hard to reach from the ports. The first is a frame whose later segments carry control bits that contradict the first segment's. The second is an orphan descriptor, because it needs the walker to sit between frames when an owned non-first slot comes up. The stimulus writes a three-slot frame in which the middle and last slots hold opposite control bits, and it hands over ownership last-to-first so the walker never sees a half-built frame. Later, after an end-of-ring wrap, it parks the walker and places a lone last-segment slot at the park position. It then confirms that no request appears, that the slot is closed with its other bits intact, and that an ordinary frame still follows.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int BIT_OWN = 31;
  localparam int BIT_IC  = 30;
  localparam int BIT_LS  = 29;
  localparam int BIT_FS  = 28;
  localparam int BIT_DC  = 27;
  localparam int BIT_DP  = 26;
  localparam int BIT_TS  = 25;
  localparam int BIT_CS  = 22;
  localparam int BIT_TER = 21;
  localparam int LEN_W   = 16;

  typedef struct packed {
    logic       crc_dis;
    logic       pad_dis;
    logic       ts_en;
    logic [1:0] csum;
  } frame_ctl_t;

  typedef struct packed {
    logic       own;
    logic       ic;
    logic       ls;
    logic       fs;
    logic       ter;
    frame_ctl_t ctl;
  } desc_view_t;

  typedef enum logic [2:0] {
    W_IDLE, W_FETCH, W_BUSY, W_CLOSE, W_SUSP
  } walk_st_t;

  function automatic desc_view_t view_of(input logic [31:0] w);
    desc_view_t v;
    v.own         = w[BIT_OWN];
    v.ic          = w[BIT_IC];
    v.ls          = w[BIT_LS];
    v.fs          = w[BIT_FS];
    v.ter         = w[BIT_TER];
    v.ctl.crc_dis = w[BIT_DC];
    v.ctl.pad_dis = w[BIT_DP];
    v.ctl.ts_en   = w[BIT_TS];
    v.ctl.csum    = w[BIT_CS+1:BIT_CS];
    return v;
  endfunction

  function automatic logic [31:0] close_word(input logic [31:0] w);
    logic [31:0] r;
    r = w;
    r[BIT_OWN] = 1'b0;
    return r;
  endfunction

  function automatic int unsigned ring_next(input int unsigned cur, input logic ter,
                                            input int unsigned n);
    if (ter || (cur + 1 >= n)) return 0;
    return cur + 1;
  endfunction
endpackage

// File: rtl/tdr_desc_mem.sv
module tdr_desc_mem
  import tdr_pkg::*;
#(
  parameter int NDESC = 8,
  parameter int IW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [IW-1:0]     cpu_idx,
  input  logic              cpu_wsel,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic [IW-1:0]     eng_idx,
  output desc_view_t        eng_view,
  output logic [LEN_W-1:0]  eng_len,
  input  logic              close_en
);
  logic [31:0] w0 [NDESC];
  logic [31:0] w1 [NDESC];

  for (genvar s = 0; s < NDESC; s++) begin : g_slot
    logic [31:0] r0, r1;
    logic        hit;
    assign hit = (cpu_idx == IW'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r0 <= '0;
        r1 <= '0;
      end else begin
        if (cpu_we && hit && !cpu_wsel)          r0 <= cpu_wdata;
        else if (close_en && eng_idx == IW'(s))  r0 <= close_word(r0);
        if (cpu_we && hit && cpu_wsel)           r1 <= cpu_wdata;
      end
    end
    assign w0[s] = r0;
    assign w1[s] = r1;
  end

  always_comb begin
    cpu_rdata = '0;
    if (int'(cpu_idx) < NDESC) cpu_rdata = cpu_wsel ? w1[cpu_idx] : w0[cpu_idx];
  end

  assign eng_view = view_of(w0[eng_idx]);
  assign eng_len  = w1[eng_idx][LEN_W-1:0];
endmodule

// File: rtl/tdr_frame_track.sv
module tdr_frame_track
  import tdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  desc_view_t cur,
  input  logic       frame_end,
  input  logic       irq_ack,
  output logic       in_frame,
  output frame_ctl_t ctl,
  output logic       tx_irq
);
  logic ic_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      ctl      <= '0;
      ic_acc   <= 1'b0;
      tx_irq   <= 1'b0;
    end else begin
      if (take && cur.fs) begin
        in_frame <= 1'b1;
        ctl      <= cur.ctl;
        ic_acc   <= cur.ic;
      end else if (take) begin
        ic_acc   <= ic_acc | cur.ic;
      end else if (frame_end) begin
        in_frame <= 1'b0;
      end
      if (frame_end && ic_acc) tx_irq <= 1'b1;
      else if (irq_ack)        tx_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/tdr_walker.sv
module tdr_walker
  import tdr_pkg::*;
#(
  parameter int NDESC = 8,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_poll,
  input  logic          irq_ack,
  input  logic          buf_done,
  input  desc_view_t    cur,
  input  logic          in_frame,
  output logic [IW-1:0] idx,
  output logic          buf_req,
  output logic          buf_unavail,
  output logic          orphan_err,
  output logic          take,
  output logic          close_en,
  output logic          frame_end,
  output logic          orphan_ev
);
  walk_st_t st, st_n;
  logic     orph_q;

  always_comb begin
    st_n = st;
    take = 1'b0;
    case (st)
      W_IDLE, W_SUSP: if (cpu_poll) st_n = W_FETCH;
      W_FETCH: begin
        if (!cur.own) st_n = W_SUSP;
        else if (cur.fs || in_frame) begin
          st_n = W_BUSY;
          take = 1'b1;
        end else st_n = W_CLOSE;
      end
      W_BUSY:  if (buf_done) st_n = W_CLOSE;
      W_CLOSE: st_n = W_FETCH;
      default: st_n = W_IDLE;
    endcase
  end

  assign close_en    = (st == W_CLOSE);
  assign frame_end   = close_en && !orph_q && cur.ls;
  assign orphan_ev   = close_en && orph_q;
  assign buf_req     = (st == W_BUSY);
  assign buf_unavail = (st == W_SUSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= W_IDLE;
      orph_q     <= 1'b0;
      idx        <= '0;
      orphan_err <= 1'b0;
    end else begin
      st <= st_n;
      if (st == W_FETCH) orph_q <= cur.own && !(cur.fs || in_frame);
      if (close_en) idx <= IW'(ring_next(int'(idx), cur.ter, NDESC));
      if (orphan_ev)    orphan_err <= 1'b1;
      else if (irq_ack) orphan_err <= 1'b0;
    end
  end
endmodule

// File: rtl/txdr_engine.sv
module txdr_engine
  import tdr_pkg::*;
#(
  parameter  int NDESC = 8,
  localparam int IW    = (NDESC > 1) ? $clog2(NDESC) : 1,
  localparam int AW    = IW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [31:0]      cpu_wdata,
  output logic [31:0]      cpu_rdata,
  input  logic             cpu_poll,
  input  logic             irq_ack,
  output logic             buf_req,
  output logic [IW-1:0]    buf_idx,
  output logic [LEN_W-1:0] buf_len,
  output logic             seg_first,
  output logic             seg_last,
  output logic             f_crc_dis,
  output logic             f_pad_dis,
  output logic             f_ts_en,
  output logic [1:0]       f_csum,
  input  logic             buf_done,
  output logic             tx_irq,
  output logic             orphan_err,
  output logic             buf_unavail
);
  desc_view_t cur;
  frame_ctl_t ctl;
  logic       in_frame;
  // internal events, named for the checker
  logic       ev_take, ev_close, ev_frame_end, ev_orphan, cur_own;

  tdr_desc_mem #(.NDESC(NDESC), .IW(IW)) u_mem (
    .clk, .rst_n, .cpu_we,
    .cpu_idx  (cpu_addr[AW-1:1]),
    .cpu_wsel (cpu_addr[0]),
    .cpu_wdata, .cpu_rdata,
    .eng_idx  (buf_idx),
    .eng_view (cur),
    .eng_len  (buf_len),
    .close_en (ev_close)
  );

  tdr_walker #(.NDESC(NDESC), .IW(IW)) u_walk (
    .clk, .rst_n, .cpu_poll, .irq_ack, .buf_done,
    .cur, .in_frame,
    .idx         (buf_idx),
    .buf_req, .buf_unavail, .orphan_err,
    .take        (ev_take),
    .close_en    (ev_close),
    .frame_end   (ev_frame_end),
    .orphan_ev   (ev_orphan)
  );

  tdr_frame_track u_frame (
    .clk, .rst_n,
    .take      (ev_take),
    .cur,
    .frame_end (ev_frame_end),
    .irq_ack,
    .in_frame, .ctl, .tx_irq
  );

  assign cur_own   = cur.own;
  assign seg_first = buf_req && cur.fs;
  assign seg_last  = buf_req && cur.ls;
  assign f_crc_dis = ctl.crc_dis;
  assign f_pad_dis = ctl.pad_dis;
  assign f_ts_en   = ctl.ts_en;
  assign f_csum    = ctl.csum;
endmodule

// File: rtl/tdr_checker.sv
module tdr_checker #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_poll,
  input logic          buf_req,
  input logic          buf_done,
  input logic [IW-1:0] buf_idx,
  input logic          cur_own,
  input logic          buf_unavail,
  input logic          tx_irq,
  input logic          orphan_err,
  input logic          ev_frame_end,
  input logic          ev_orphan,
  input logic          f_crc_dis,
  input logic [1:0]    f_csum
);
  AST_REQ_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_req) |-> cur_own);                                          // R1
  AST_WAKE_BY_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_unavail) |-> $past(cpu_poll));                              // R2
  AST_CTRL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_req && $past(buf_req)) |-> ($stable(f_crc_dis) && $stable(f_csum))); // R5
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> $past(ev_frame_end));                               // R7
  AST_ORPHAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(orphan_err) |-> $past(ev_orphan));                              // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_req && !buf_done) |=> (buf_req && $stable(buf_idx)));            // R10
endmodule

bind txdr_engine tdr_checker #(.IW(IW)) u_chk (
  .clk, .rst_n, .cpu_poll, .buf_req, .buf_done, .buf_idx, .cur_own,
  .buf_unavail, .tx_irq, .orphan_err, .ev_frame_end, .ev_orphan,
  .f_crc_dis, .f_csum
);

// File: tb/tb_txdr_engine.sv
module tb_txdr_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_poll = 1'b0;
  logic        irq_ack = 1'b0;
  logic        buf_req;
  logic [2:0]  buf_idx;
  logic [15:0] buf_len;
  logic        seg_first, seg_last, f_crc_dis, f_pad_dis, f_ts_en;
  logic [1:0]  f_csum;
  logic        buf_done = 1'b0;
  logic        tx_irq, orphan_err, buf_unavail;

  int checks = 0;
  int errors = 0;
  int nreq = 0;
  logic req_q = 1'b0;
  bit finished = 0;

  always #2 clk = ~clk;

  txdr_engine #(.NDESC(8)) dut (.*);

  always @(posedge clk) begin
    req_q <= buf_req;
    if (buf_req && !req_q) nreq <= nreq + 1;
  end

  // {control word, expected {crc_dis, pad_dis, ts_en, csum}}
  localparam logic [36:0] VEC [6] = '{
    {32'hB000_0000, 5'b000_00},
    {32'hB800_0000, 5'b100_00},
    {32'hB440_1234, 5'b010_01},
    {32'hB280_0000, 5'b001_10},
    {32'hB0C0_0000, 5'b000_11},
    {32'hBEC0_00A5, 5'b111_11}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); cpu_we = 1'b1; cpu_addr = 4'(a); cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); cpu_addr = 4'(a); #1; d = cpu_rdata;
  endtask

  task automatic pulse_poll();
    @(negedge clk); cpu_poll = 1'b1;
    @(negedge clk); cpu_poll = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic serve(input int ei, input int el, input logic [4:0] ec,
                       input logic ef, input logic els, input string tag);
    int t = 0;
    while (!buf_req && t < 500) begin @(negedge clk); t++; end
    chk("R1 request seen", 32'(buf_req), 1);
    chk("R10 index", 32'(buf_idx), 32'(ei));
    chk("R10 length", 32'(buf_len), 32'(el));
    chk(tag, 32'({f_crc_dis, f_pad_dis, f_ts_en, f_csum}), 32'(ec));
    chk("R4 first", 32'(seg_first), 32'(ef));
    chk("R4 last", 32'(seg_last), 32'(els));
    repeat (2) @(negedge clk);
    chk("R10 held", 32'({buf_req, buf_idx}), 32'({1'b1, 3'(ei)}));
    buf_done = 1'b1;
    @(negedge clk); buf_done = 1'b0;
  endtask

  task automatic wait_park();
    int t = 0;
    while (!buf_unavail && t < 500) begin @(negedge clk); t++; end
    chk("R2 parked", 32'(buf_unavail), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 outputs", 32'({buf_req, tx_irq, orphan_err, buf_unavail, seg_first, seg_last}), 0);
    chk("R11 ctl", 32'({f_crc_dis, f_pad_dis, f_ts_en, f_csum}), 0);

    // table: single-segment frames, one per slot, R6 and R5 over all codes
    for (int i = 0; i < 6; i++) begin
      logic [31:0] w;
      logic [4:0]  e;
      logic [31:0] rb;
      w = VEC[i][36:5];
      e = VEC[i][4:0];
      wr(2*i + 1, 32'(16 + i));
      wr(2*i, w);
      pulse_poll();
      serve(i, 16 + i, e, 1'b1, 1'b1, "R6 R5 frame controls");
      wait_park();
      rd(2*i, rb);
      chk("R3 closed word", rb, w & 32'h7FFF_FFFF);
    end

    // R2 / R1: poll while slot 6 still belongs to software
    snap = nreq;
    pulse_poll();
    wait_park();
    repeat (3) @(negedge clk);
    chk("R1 no request on unowned", 32'(nreq), 32'(snap));
    chk("R2 still parked", 32'(buf_unavail), 1);

    // three-slot frame 6,7,0; later slots carry contrary controls
    wr(13, 32'd100); wr(15, 32'd200); wr(1, 32'd300);
    wr(0,  32'hE800_0000);  // own, IC, LS, DC (DC ignored)
    wr(14, 32'h8440_0000);  // own, DP, csum 01 (ignored)
    wr(12, 32'h9880_0000);  // own, FS, DC, csum 10
    pulse_poll();
    serve(6, 100, 5'b100_10, 1'b1, 1'b0, "R6 first seg");
    chk("R7 no irq mid frame", 32'(tx_irq), 0);
    serve(7, 200, 5'b100_10, 1'b0, 1'b0, "R5 middle seg ignored");
    chk("R7 no irq before last", 32'(tx_irq), 0);
    serve(0, 300, 5'b100_10, 1'b0, 1'b1, "R5 last seg ignored");
    wait_park();
    chk("R7 irq after frame", 32'(tx_irq), 1);
    rd(12, d); chk("R3 first closed", d, 32'h1880_0000);
    rd(0, d);  chk("R3 last closed", d, 32'h6800_0000);
    rd(13, d); chk("R3 length kept", d, 32'd100);
    pulse_ack();
    chk("R7 ack clears", 32'(tx_irq), 0);

    // R8: slot 1 carries end-of-ring, slot 0 must follow
    wr(1, 32'd55); wr(0, 32'hB000_0000);
    wr(3, 32'd44); wr(2, 32'hB020_0000);
    pulse_poll();
    serve(1, 44, 5'b000_00, 1'b1, 1'b1, "R8 ter slot");
    serve(0, 55, 5'b000_00, 1'b1, 1'b1, "R8 wrapped to 0");
    wait_park();
    chk("R7 no irq without request", 32'(tx_irq), 0);

    // R9: orphan last segment at slot 1
    wr(2, 32'hA000_000F);
    snap = nreq;
    pulse_poll();
    wait_park();
    chk("R9 no data request", 32'(nreq), 32'(snap));
    chk("R9 orphan flag", 32'(orphan_err), 1);
    rd(2, d); chk("R9 orphan closed", d, 32'h2000_000F);
    chk("R9 no irq", 32'(tx_irq), 0);
    wr(5, 32'd8); wr(4, 32'hB000_0000);
    pulse_poll();
    serve(2, 8, 5'b000_00, 1'b1, 1'b1, "R9 next frame after orphan");
    wait_park();
    chk("R9 flag sticky", 32'(orphan_err), 1);
    pulse_ack();
    chk("R9 ack clears", 32'(orphan_err), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule